// File: doc/BRIEF.md
# DMA Channel Command and Status Register Front End

This block is the software-facing register set of a single DMA channel. It sits on a 32-bit register bus and holds a control word plus six pointer-type registers. The control word is not a plain storage register. Each write is a set of one-shot commands, and each command sets or clears one of four status flags. A reset command wipes the flag group in a single write.

A transfer engine, which is not part of this block, reads three of the flags as outputs: enable, direction and update mode. When a transfer finishes, the engine reports it with a one-cycle completion pulse. That pulse raises the complete flag and drops enable.

Reads are registered and return one cycle after the request. Only full-width accesses are accepted, which means all byte enables must be set. Other accesses do nothing.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, the enable, update, complete and direction flags are all 0, and every pointer register reads 0.
- R2: A full-width write to control offset 0x0 with bit 0 set and bit 4 clear sets the enable flag. A write with bit 0 clear leaves the enable flag unchanged.
- R3: A control write with bit 1 set and bit 4 clear sets the update-mode flag. Bit 1 clear leaves it unchanged.
- R4: A control write with bit 2 set and bit 4 clear clears the complete flag. Bit 2 clear leaves it unchanged.
- R5: A control write with bit 3 set and bit 4 clear sets the direction flag, where 1 means device-to-memory. Bit 3 clear leaves it unchanged.
- R6: A control write with bit 4 set clears the enable, update, complete and direction flags together. It overrides any set command carried in the same word.
- R7: Six registers hold the full 32-bit written value and read it back unchanged:
  - current pointer at 0x4000
  - limit at 0x4004
  - start at 0x4008
  - stop at 0x400C
  - initial buffer at 0x4200
  - size at 0x4204
- R8: An access whose byte enables are not all 1 changes no state. For a read of that kind, the read-valid strobe stays 0 and the read data is 0.
- R9: A full-width read of any other offset returns 0 with the read-valid strobe set. A write to such an offset changes no register.
- R10: A cycle with the completion pulse high sets the complete flag and clears the enable flag on that clock edge. It does this even when a control write in the same cycle sets enable or clears complete.
- R11: Reading the control offset returns enable in bit 0, update in bit 1, complete in bit 2 and direction in bit 3. All higher bits read 0.
- R12: Read data and the read-valid strobe appear on the clock edge that samples the read request.
- R13: The engine-facing outputs for enable, direction and update always equal the stored flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | Byte offset of the access |
| req_be | input | DATA_W/8 (4) | Byte enables; all must be set for the access to act |
| req_wdata | input | DATA_W (32) | Write data |
| rd_valid | output | 1 | Read data strobe, one cycle after a full-width read |
| rd_data | output | DATA_W (32) | Registered read data |
| xfer_done | input | 1 | Completion pulse from the transfer engine |
| chan_enable | output | 1 | Channel enable flag |
| chan_dev2mem | output | 1 | Direction flag, 1 = device to memory |
| chan_update | output | 1 | Update-mode flag |

## Verification
The bench builds the block with its defaults: a 16-bit offset and a 32-bit data word. These widths are enough to reach both pointer groups at 0x4000 and 0x4200, the aliasing candidates next to them, and a full 32-bit value pattern in every pointer register. Random command words cover every combination of the five command bits, including reset mixed with set commands. Random completion pulses coincide with control writes, so the completion-over-command ordering is exercised. A share of partial byte-enable accesses shows that such accesses leave every flag and pointer untouched.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              xfer_done,
  output logic              chan_enable,
  output logic              chan_dev2mem,
  output logic              chan_update
);
  localparam int NPTR = 6;
  localparam int BE_W = DATA_W / 8;
  localparam logic [ADDR_W-1:0] CTRL_OFS = '0;

  logic en_q, upd_q, cmpl_q, dir_q;
  logic full, wr_ok, rd_ok, ctrl_hit;
  logic [NPTR-1:0] ptr_hit;
  logic [DATA_W-1:0] ptr_q [NPTR];
  logic [DATA_W-1:0] rd_mux;

  assign full     = req_be == {BE_W{1'b1}};
  assign wr_ok    = req_valid & req_write & full;
  assign rd_ok    = req_valid & ~req_write & full;
  assign ctrl_hit = req_addr == CTRL_OFS;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    localparam int OFS_I = (g < 4) ? ('h4000 + 4 * g) : ('h4200 + 4 * (g - 4));
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(OFS_I);
    assign ptr_hit[g] = req_addr == OFS;
    always_ff @(posedge clk) begin
      if (!rst_n)
        ptr_q[g] <= '0;
      else if (wr_ok && ptr_hit[g])
        ptr_q[g] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      upd_q  <= 1'b0;
      cmpl_q <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      if (wr_ok && ctrl_hit) begin
        if (req_wdata[4]) begin
          en_q   <= 1'b0;
          upd_q  <= 1'b0;
          cmpl_q <= 1'b0;
          dir_q  <= 1'b0;
        end else begin
          if (req_wdata[0]) en_q   <= 1'b1;
          if (req_wdata[1]) upd_q  <= 1'b1;
          if (req_wdata[2]) cmpl_q <= 1'b0;
          if (req_wdata[3]) dir_q  <= 1'b1;
        end
      end
      if (xfer_done) begin
        cmpl_q <= 1'b1;
        en_q   <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (ctrl_hit)
      rd_mux[3:0] = {dir_q, cmpl_q, upd_q, en_q};
    for (int i = 0; i < NPTR; i++)
      if (ptr_hit[i]) rd_mux = ptr_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_ok;
      rd_data  <= rd_ok ? rd_mux : '0;
    end
  end

  assign chan_enable  = en_q;
  assign chan_dev2mem = dir_q;
  assign chan_update  = upd_q;
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W/8-1:0] req_be,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              xfer_done,
  input logic              chan_enable,
  input logic              chan_dev2mem,
  input logic              chan_update,
  input logic              cmpl
);
  logic full_c, ctrl_wr, known;
  assign full_c  = &req_be;
  assign ctrl_wr = req_valid && req_write && full_c && req_addr == '0;
  assign known   = req_addr == '0 || req_addr == 'h4000 || req_addr == 'h4004 ||
                   req_addr == 'h4008 || req_addr == 'h400C ||
                   req_addr == 'h4200 || req_addr == 'h4204;

  // R10
  done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !chan_enable && cmpl);

  // R6
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && req_wdata[4] && !xfer_done |=> !chan_enable && !chan_update && !chan_dev2mem && !cmpl);

  // R2
  set_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && req_wdata[0] && !req_wdata[4] && !xfer_done |=> chan_enable);

  // R8
  partial_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !full_c && !xfer_done |=> $stable(chan_enable) && $stable(chan_update) &&
    $stable(chan_dev2mem) && $stable(cmpl) && !rd_valid && rd_data == '0);

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && full_c && !known |=> rd_valid && rd_data == '0);

  // R5
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(chan_dev2mem) && $stable(chan_update));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
  .rd_valid(rd_valid), .rd_data(rd_data), .xfer_done(xfer_done),
  .chan_enable(chan_enable), .chan_dev2mem(chan_dev2mem),
  .chan_update(chan_update), .cmpl(cmpl_q));

// File: tb/dma_chan_regs_tb_top.sv
module dma_chan_regs_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0, xfer_done = 0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid, chan_enable, chan_dev2mem, chan_update;
  logic [31:0] rd_data;

  int checks = 0, failures = 0;
  logic m_en, m_upd, m_cmpl, m_dir;
  logic [31:0] m_ptr [6];
  logic [31:0] got;
  logic        got_v;

  always #2 clk = ~clk;

  dma_chan_regs dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .xfer_done(xfer_done),
    .chan_enable(chan_enable), .chan_dev2mem(chan_dev2mem), .chan_update(chan_update));

  function automatic int ptr_idx(input logic [15:0] a);
    case (a)
      16'h4000: return 0;
      16'h4004: return 1;
      16'h4008: return 2;
      16'h400C: return 3;
      16'h4200: return 4;
      16'h4204: return 5;
      default:  return -1;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [15:0] a);
    int k;
    k = ptr_idx(a);
    if (a == 16'h0) return {28'h0, m_dir, m_cmpl, m_upd, m_en};
    if (k >= 0) return m_ptr[k];
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic wr, input logic [15:0] a, input logic [3:0] be,
                    input logic [31:0] d, input logic done);
    logic full;
    int k;
    full = be == 4'hF;
    req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = d; xfer_done = done;
    @(negedge clk);
    got = rd_data; got_v = rd_valid;
    req_valid = 0; req_write = 0; xfer_done = 0; req_be = '0;
    if (wr && full) begin
      k = ptr_idx(a);
      if (k >= 0) m_ptr[k] = d;
      if (a == 16'h0) begin
        if (d[4]) begin m_en = 0; m_upd = 0; m_cmpl = 0; m_dir = 0; end
        else begin
          if (d[0]) m_en = 1;
          if (d[1]) m_upd = 1;
          if (d[2]) m_cmpl = 0;
          if (d[3]) m_dir = 1;
        end
      end
    end
    if (done) begin m_cmpl = 1; m_en = 0; end
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a);
    logic [31:0] e;
    e = exp_read(a);
    op(0, a, 4'hF, 32'h0, 0);
    chk(req, got, e);
    chk("R12 rd_valid", {31'h0, got_v}, 32'h1);
  endtask

  task automatic out_chk(input string req);
    chk(req, {29'h0, chan_enable, chan_dev2mem, chan_update}, {29'h0, m_en, m_dir, m_upd});
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] addrs [10];
    logic [15:0] a;
    logic [3:0]  be;
    logic [31:0] d;
    int unsigned seed;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    addrs = '{16'h0, 16'h4000, 16'h4004, 16'h4008, 16'h400C, 16'h4200, 16'h4204,
              16'h4010, 16'h4208, 16'h0004};
    m_en = 0; m_upd = 0; m_cmpl = 0; m_dir = 0;
    for (int i = 0; i < 6; i++) m_ptr[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    out_chk("R1 outputs");
    rd_chk("R1 ctrl", 16'h0);
    rd_chk("R1 ptr", 16'h4204);

    // R2 R3 R5 R11 set commands
    op(1, 16'h0, 4'hF, 32'h1, 0);
    rd_chk("R2 enable set", 16'h0);
    op(1, 16'h0, 4'hF, 32'h0, 0);
    rd_chk("R2 zero write holds", 16'h0);
    op(1, 16'h0, 4'hF, 32'h2, 0);
    rd_chk("R3 update set", 16'h0);
    op(1, 16'h0, 4'hF, 32'h8, 0);
    rd_chk("R5 direction set", 16'h0);
    out_chk("R13 outputs");
    op(1, 16'h0, 4'hF, 32'hFFFF_FFE0, 0);
    rd_chk("R11 upper bits zero", 16'h0);

    // R10 done wins over same-cycle set-enable/clear-complete
    op(1, 16'h0, 4'hF, 32'h5, 1);
    rd_chk("R10 done priority", 16'h0);
    chk("R10 cmpl", {31'h0, got[2]}, 32'h1);
    // R4 clear complete
    op(1, 16'h0, 4'hF, 32'h4, 0);
    rd_chk("R4 clear complete", 16'h0);
    // R6 reset beats set
    op(1, 16'h0, 4'hF, 32'h1, 1);
    op(1, 16'h0, 4'hF, 32'h1F, 0);
    rd_chk("R6 reset priority", 16'h0);
    chk("R6 all clear", got, 32'h0);

    // R7 pointers
    for (int i = 1; i < 7; i++) op(1, addrs[i], 4'hF, 32'hA5A5_0000 + 32'(i * 17), 0);
    for (int i = 1; i < 7; i++) rd_chk("R7 pointer readback", addrs[i]);

    // R8 partial width
    op(1, 16'h4000, 4'h3, 32'hDEAD_BEEF, 0);
    rd_chk("R8 partial write ignored", 16'h4000);
    op(1, 16'h0, 4'h1, 32'h1, 0);
    rd_chk("R8 partial ctrl ignored", 16'h0);
    op(0, 16'h4000, 4'h7, 32'h0, 0);
    chk("R8 partial read data", got, 32'h0);
    chk("R8 partial read valid", {31'h0, got_v}, 32'h0);

    // R9 unmapped
    op(1, 16'h4010, 4'hF, 32'h1234_5678, 0);
    rd_chk("R9 unmapped read", 16'h4010);
    rd_chk("R9 neighbour untouched", 16'h400C);

    // random mix
    for (int n = 0; n < 600; n++) begin
      a  = addrs[$urandom % 10];
      if (($urandom % 6) == 0) a = 16'($urandom) & 16'hFFFC;
      be = (($urandom % 8) == 0) ? 4'($urandom) : 4'hF;
      d  = (a == 16'h0) ? 32'($urandom % 32) : $urandom;
      if ($urandom % 2) begin
        op(1, a, be, d, ($urandom % 5) == 0);
      end else if (be == 4'hF) begin
        d = exp_read(a);
        op(0, a, be, 32'h0, ($urandom % 5) == 0);
        chk("R7 R9 R11 random read", got, d);
      end else begin
        op(0, a, be, 32'h0, 0);
        chk("R8 random partial read", got, 32'h0);
      end
      out_chk("R13 random outputs");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule